// File: doc/BRIEF.md
# SDRAM Command Decoder

This block sits behind the command pins of a double-data-rate SDRAM device model or controller monitor. On every rising clock edge it samples chip select, the three strobe pins, clock enable, the row/column address bus and the bank address. It turns the pin pattern into exactly one command class, or into none while the clock is held off. The command and the address fields that belong to it appear one cycle after the sampling edge.

The fields that a command carries are kept in holding registers. The row and bank are taken from an activate, the column, bank and auto-precharge flag from a read or write, and the burst and latency settings from a mode load. They stay unchanged until the next command of the same kind. Address bit 10 has a double role. On reads and writes it asks for auto-precharge of the addressed bank. On a precharge it widens the operation to every bank. The block turns both uses into a per-bank precharge mask that is valid for one cycle. A falling clock enable is classified as power-down entry, or as self-refresh entry when the refresh pattern is present at that edge.

Top module: `sdram_cmd_decoder`

## Requirements
- R1: While reset is asserted, every output is zero.
- R2: With clock enable high at this edge and the previous one, and chip select low, the strobe levels {ras_n,cas_n,we_n} decode as: 111 no-op, 011 activate, 101 read, 100 write, 010 precharge, 001 auto-refresh, 000 mode load. cmd_oh bit positions are 0 no-op, 1 activate, 2 read, 3 write, 4 precharge, 5 auto-refresh, 6 self-refresh entry, 7 mode load, 8 power-down entry. The bit is set in the cycle after the sampling edge.
- R3: Chip select high with clock enable steady high decodes as no-op, and every held field keeps its value.
- R4: An activate loads row_addr with all 13 address bits and bank_sel with the bank address. row_addr changes only after an activate.
- R5: A read or write loads col_addr with address bits 9:0, bank_sel with the bank address and auto_pre with address bit 10. col_addr and auto_pre change only after a read or write.
- R6: A precharge with address bit 10 high gives pre_mask 4'b1111 whatever the bank address. With bit 10 low it gives only the bit of the addressed bank (bit n for bank n). It also loads bank_sel.
- R7: pre_mask is nonzero only in the cycle after a precharge, or after a read or write with auto-precharge. In the latter case it holds the addressed bank's bit. Otherwise it is 4'b0000.
- R8: Clock enable high at the previous edge and low at this one decodes as self-refresh entry when chip select is low and the strobes are 001. Any other pattern decodes as power-down entry. Neither loads a field.
- R9: Clock enable low at both the previous and this edge gives cmd_oh all zero, whatever the pins. Low then high gives a no-op. The previous edge counts as low right after reset.
- R10: A mode load with bank address 00 sets mode_bl from bits 2:0 (001 gives 2, 010 gives 4, 011 gives 8, other codes 0), mode_ilv from bit 3 (1 means interleaved) and mode_cl2 (latency in half cycles) from bits 6:4 (010 gives 4, 110 gives 5, other codes 0). A mode load with a nonzero bank address leaves these fields unchanged.
- R11: At most one cmd_oh bit is set in any cycle.
- R12: The unused strobe pattern 110 with chip select low decodes as no-op and loads no field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | 13 | Address bus; bit 10 is the precharge qualifier |
| ba | input | 2 | Bank address |
| cmd_oh | output | 9 | One-hot command class |
| row_addr | output | 13 | Held row of the last activate |
| col_addr | output | 10 | Held column of the last read or write |
| bank_sel | output | 2 | Held bank of the last activate, read, write or precharge |
| auto_pre | output | 1 | Held auto-precharge flag of the last read or write |
| pre_mask | output | 4 | One-cycle per-bank precharge mask |
| mode_bl | output | 4 | Held burst length (2, 4, 8, 0 if illegal) |
| mode_ilv | output | 1 | Held burst order, 1 for interleaved |
| mode_cl2 | output | 3 | Held CAS latency in half cycles (4, 5, 0 if illegal) |

## Verification
Two things can meet in one edge. A falling clock enable can coincide with any strobe pattern, and then the entry classification must win over the command the strobes spell. The bench drives activate, read and refresh patterns exactly on the edge where clock enable drops. It expects self-refresh entry only for the refresh pattern, power-down entry for the rest, and no change in row, column or mode fields. A read with bit 10 high likewise lands the column load and the one-cycle precharge mask in the same cycle. The scoreboard compares both in that single cycle.

// File: rtl/sdram_dec_pkg.sv
package sdram_dec_pkg;

  localparam int NCMD = 9;
  localparam int IX_NOP  = 0;
  localparam int IX_ACT  = 1;
  localparam int IX_RD   = 2;
  localparam int IX_WR   = 3;
  localparam int IX_PRE  = 4;
  localparam int IX_REF  = 5;
  localparam int IX_SREF = 6;
  localparam int IX_MRS  = 7;
  localparam int IX_PDN  = 8;

  typedef enum logic [3:0] {
    C_HELD, C_NOP, C_ACT, C_RD, C_WR, C_PRE, C_REF, C_SREF, C_MRS, C_PDN
  } cmd_e;

  function automatic logic [NCMD-1:0] f_onehot(input cmd_e c);
    logic [NCMD-1:0] v;
    v = '0;
    case (c)
      C_NOP:   v[IX_NOP]  = 1'b1;
      C_ACT:   v[IX_ACT]  = 1'b1;
      C_RD:    v[IX_RD]   = 1'b1;
      C_WR:    v[IX_WR]   = 1'b1;
      C_PRE:   v[IX_PRE]  = 1'b1;
      C_REF:   v[IX_REF]  = 1'b1;
      C_SREF:  v[IX_SREF] = 1'b1;
      C_MRS:   v[IX_MRS]  = 1'b1;
      C_PDN:   v[IX_PDN]  = 1'b1;
      default: v = '0;
    endcase
    return v;
  endfunction

  // burst length code -> beats, 0 marks an illegal code
  function automatic logic [3:0] f_burst_len(input logic [2:0] code);
    case (code)
      3'b001:  return 4'd2;
      3'b010:  return 4'd4;
      3'b011:  return 4'd8;
      default: return 4'd0;
    endcase
  endfunction

  // latency code -> latency in half clock cycles, 0 marks an illegal code
  function automatic logic [2:0] f_cl_half(input logic [2:0] code);
    case (code)
      3'b010:  return 3'd4;
      3'b110:  return 3'd5;
      default: return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/sdc_pin_classify.sv
module sdc_pin_classify
  import sdram_dec_pkg::*;
(
  input  logic cke_prev,
  input  logic cke,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);

  logic [2:0] strobes;
  logic       ev_cke_fall;
  logic       ev_cke_rise;
  logic       ev_cke_off;

  assign strobes     = {ras_n, cas_n, we_n};
  assign ev_cke_fall = cke_prev & ~cke;
  assign ev_cke_rise = ~cke_prev & cke;
  assign ev_cke_off  = ~cke_prev & ~cke;

  always_comb begin
    cmd = C_HELD;
    if (ev_cke_off) begin
      cmd = C_HELD;
    end else if (ev_cke_rise) begin
      cmd = C_NOP;
    end else if (ev_cke_fall) begin
      cmd = (!cs_n && strobes == 3'b001) ? C_SREF : C_PDN;
    end else if (cs_n) begin
      cmd = C_NOP;
    end else begin
      case (strobes)
        3'b011:  cmd = C_ACT;
        3'b101:  cmd = C_RD;
        3'b100:  cmd = C_WR;
        3'b010:  cmd = C_PRE;
        3'b001:  cmd = C_REF;
        3'b000:  cmd = C_MRS;
        default: cmd = C_NOP;
      endcase
    end
  end

endmodule

// File: rtl/sdc_bank_mask.sv
module sdc_bank_mask #(
  parameter int BA_W = 2,
  localparam int NBANK = 1 << BA_W
) (
  input  logic [BA_W-1:0]  ba,
  input  logic             en,
  input  logic             all,
  output logic [NBANK-1:0] mask
);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign mask[b] = en & (all | (ba == BA_W'(b)));
  end

endmodule

// File: rtl/sdc_field_regs.sv
module sdc_field_regs
  import sdram_dec_pkg::*;
#(
  parameter int ROW_W = 13,
  parameter int COL_W = 10,
  parameter int BA_W  = 2,
  parameter int AP_BIT = 10,
  localparam int NBANK = 1 << BA_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cmd_e             cmd,
  input  logic [ROW_W-1:0] addr,
  input  logic [BA_W-1:0]  ba,
  input  logic [NBANK-1:0] mask_next,
  output logic [NCMD-1:0]  cmd_oh,
  output logic [ROW_W-1:0] row_addr,
  output logic [COL_W-1:0] col_addr,
  output logic [BA_W-1:0]  bank_sel,
  output logic             auto_pre,
  output logic [NBANK-1:0] pre_mask,
  output logic [3:0]       mode_bl,
  output logic             mode_ilv,
  output logic [2:0]       mode_cl2
);

  logic ld_row, ld_col, ld_bank, ld_mode;

  assign ld_row  = (cmd == C_ACT);
  assign ld_col  = (cmd == C_RD) || (cmd == C_WR);
  assign ld_bank = ld_row || ld_col || (cmd == C_PRE);
  assign ld_mode = (cmd == C_MRS) && (ba == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_oh   <= '0;
      row_addr <= '0;
      col_addr <= '0;
      bank_sel <= '0;
      auto_pre <= 1'b0;
      pre_mask <= '0;
      mode_bl  <= '0;
      mode_ilv <= 1'b0;
      mode_cl2 <= '0;
    end else begin
      cmd_oh   <= f_onehot(cmd);
      pre_mask <= mask_next;
      if (ld_row)  row_addr <= addr;
      if (ld_bank) bank_sel <= ba;
      if (ld_col) begin
        col_addr <= addr[COL_W-1:0];
        auto_pre <= addr[AP_BIT];
      end
      if (ld_mode) begin
        mode_bl  <= f_burst_len(addr[2:0]);
        mode_ilv <= addr[3];
        mode_cl2 <= f_cl_half(addr[6:4]);
      end
    end
  end

  AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_oh)); // R11

  AST_ROW_ONLY_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(row_addr) |-> cmd_oh[IX_ACT]); // R4

  AST_COL_ONLY_RW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(col_addr) |-> (cmd_oh[IX_RD] || cmd_oh[IX_WR])); // R5

  AST_MODE_ONLY_MRS: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(mode_bl) || !$stable(mode_cl2) || !$stable(mode_ilv)) |-> cmd_oh[IX_MRS]); // R10

  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_oh[IX_PRE] || cmd_oh[IX_RD] || cmd_oh[IX_WR]) |-> (pre_mask == '0)); // R7

  AST_PRE_HAS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_oh[IX_PRE] |-> (pre_mask != '0)); // R6

endmodule

// File: rtl/sdram_cmd_decoder.sv
module sdram_cmd_decoder
  import sdram_dec_pkg::*;
#(
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int BA_W   = 2,
  parameter int AP_BIT = 10,
  localparam int NBANK = 1 << BA_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke,
  input  logic             cs_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic [ROW_W-1:0] addr,
  input  logic [BA_W-1:0]  ba,
  output logic [NCMD-1:0]  cmd_oh,
  output logic [ROW_W-1:0] row_addr,
  output logic [COL_W-1:0] col_addr,
  output logic [BA_W-1:0]  bank_sel,
  output logic             auto_pre,
  output logic [NBANK-1:0] pre_mask,
  output logic [3:0]       mode_bl,
  output logic             mode_ilv,
  output logic [2:0]       mode_cl2
);

  logic             cke_last;
  cmd_e             cmd;
  logic             ev_pre;
  logic             ev_auto;
  logic             mask_en;
  logic             mask_all;
  logic [NBANK-1:0] mask_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cke_last <= 1'b0;
    else        cke_last <= cke;
  end

  sdc_pin_classify i_classify (
    .cke_prev (cke_last),
    .cke      (cke),
    .cs_n     (cs_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .cmd      (cmd)
  );

  assign ev_pre   = (cmd == C_PRE);
  assign ev_auto  = ((cmd == C_RD) || (cmd == C_WR)) && addr[AP_BIT];
  assign mask_en  = ev_pre || ev_auto;
  assign mask_all = ev_pre && addr[AP_BIT];

  sdc_bank_mask #(.BA_W(BA_W)) i_mask (
    .ba   (ba),
    .en   (mask_en),
    .all  (mask_all),
    .mask (mask_next)
  );

  sdc_field_regs #(
    .ROW_W (ROW_W), .COL_W (COL_W), .BA_W (BA_W), .AP_BIT (AP_BIT)
  ) i_fields (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       (cmd),
    .addr      (addr),
    .ba        (ba),
    .mask_next (mask_next),
    .cmd_oh    (cmd_oh),
    .row_addr  (row_addr),
    .col_addr  (col_addr),
    .bank_sel  (bank_sel),
    .auto_pre  (auto_pre),
    .pre_mask  (pre_mask),
    .mode_bl   (mode_bl),
    .mode_ilv  (mode_ilv),
    .mode_cl2  (mode_cl2)
  );

  AST_ENTRY_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_oh[IX_SREF] || cmd_oh[IX_PDN]) |-> (!cke_last && $past(cke_last))); // R8

  AST_HELD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_last && !$past(cke_last)) |-> (cmd_oh == '0)); // R9

  AST_RISE_IS_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (cke_last && !$past(cke_last)) |-> cmd_oh[IX_NOP]); // R9

endmodule

// File: tb/test_sdram_cmd_decoder.sv
`timescale 1ns/1ps
module test_sdram_cmd_decoder;

  typedef struct {
    logic [8:0]  oh;
    logic [12:0] row;
    logic [9:0]  col;
    logic [1:0]  bank;
    logic        ap;
    logic [3:0]  mask;
    logic [3:0]  bl;
    logic        ilv;
    logic [2:0]  cl;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke = 1'b0, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [12:0] addr = '0;
  logic [1:0]  ba = '0;
  logic [8:0]  cmd_oh;
  logic [12:0] row_addr;
  logic [9:0]  col_addr;
  logic [1:0]  bank_sel;
  logic        auto_pre;
  logic [3:0]  pre_mask;
  logic [3:0]  mode_bl;
  logic        mode_ilv;
  logic [2:0]  mode_cl2;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  exp_t q[$];

  // model state
  logic        m_ckep = 1'b0;
  logic [12:0] m_row = '0;
  logic [9:0]  m_col = '0;
  logic [1:0]  m_bank = '0;
  logic        m_ap = 1'b0;
  logic [3:0]  m_bl = '0;
  logic        m_ilv = 1'b0;
  logic [2:0]  m_cl = '0;

  always #2 clk = ~clk;

  sdram_cmd_decoder i_sdram_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .addr(addr), .ba(ba), .cmd_oh(cmd_oh),
    .row_addr(row_addr), .col_addr(col_addr), .bank_sel(bank_sel),
    .auto_pre(auto_pre), .pre_mask(pre_mask), .mode_bl(mode_bl),
    .mode_ilv(mode_ilv), .mode_cl2(mode_cl2)
  );

  function automatic logic [3:0] bl_of(input logic [2:0] c);
    if (c == 3'd1) return 4'd2;
    if (c == 3'd2) return 4'd4;
    if (c == 3'd3) return 4'd8;
    return 4'd0;
  endfunction

  function automatic logic [2:0] cl_of(input logic [2:0] c);
    if (c == 3'b010) return 3'd4;
    if (c == 3'b110) return 3'd5;
    return 3'd0;
  endfunction

  task automatic drive(input logic c, input logic r, input logic ca, input logic w,
                       input logic k, input logic [12:0] a, input logic [1:0] b,
                       input string tag);
    exp_t e;
    int   bit_ix;
    @(negedge clk);
    cs_n = c; ras_n = r; cas_n = ca; we_n = w; cke = k; addr = a; ba = b;
    bit_ix = -1;
    e.mask = 4'b0000;
    if (!m_ckep && !k)      bit_ix = -1;
    else if (!m_ckep)       bit_ix = 0;
    else if (!k)            bit_ix = (!c && {r,ca,w} == 3'b001) ? 6 : 8;
    else if (c)             bit_ix = 0;
    else begin
      case ({r,ca,w})
        3'b011: begin bit_ix = 1; m_row = a; m_bank = b; end
        3'b101, 3'b100: begin
          bit_ix = ({r,ca,w} == 3'b101) ? 2 : 3;
          m_col = a[9:0]; m_bank = b; m_ap = a[10];
          if (a[10]) e.mask = 4'b0001 << b;
        end
        3'b010: begin
          bit_ix = 4; m_bank = b;
          e.mask = a[10] ? 4'b1111 : (4'b0001 << b);
        end
        3'b001: bit_ix = 5;
        3'b000: begin
          bit_ix = 7;
          if (b == 2'b00) begin
            m_bl = bl_of(a[2:0]); m_ilv = a[3]; m_cl = cl_of(a[6:4]);
          end
        end
        default: bit_ix = 0;
      endcase
    end
    m_ckep = k;
    e.oh = (bit_ix < 0) ? 9'd0 : (9'd1 << bit_ix);
    e.row = m_row; e.col = m_col; e.bank = m_bank; e.ap = m_ap;
    e.bl = m_bl; e.ilv = m_ilv; e.cl = m_cl; e.tag = tag;
    q.push_back(e);
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_cmp++;
      if (cmd_oh !== e.oh || row_addr !== e.row || col_addr !== e.col ||
          bank_sel !== e.bank || auto_pre !== e.ap || pre_mask !== e.mask ||
          mode_bl !== e.bl || mode_ilv !== e.ilv || mode_cl2 !== e.cl) begin
        n_bad++;
        $display("FAIL %s: actual oh=%b row=%h col=%h bank=%0d ap=%b mask=%b bl=%0d ilv=%b cl=%0d | expected oh=%b row=%h col=%h bank=%0d ap=%b mask=%b bl=%0d ilv=%b cl=%0d",
          e.tag, cmd_oh, row_addr, col_addr, bank_sel, auto_pre, pre_mask, mode_bl, mode_ilv, mode_cl2,
          e.oh, e.row, e.col, e.bank, e.ap, e.mask, e.bl, e.ilv, e.cl);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    n_cmp++;
    if (cmd_oh !== '0 || row_addr !== '0 || col_addr !== '0 || bank_sel !== '0 ||
        auto_pre !== 1'b0 || pre_mask !== '0 || mode_bl !== '0 || mode_ilv !== 1'b0 ||
        mode_cl2 !== '0) begin
      n_bad++;
      $display("FAIL R1 reset: actual oh=%b row=%h mask=%b, expected all zero", cmd_oh, row_addr, pre_mask);
    end
    @(negedge clk); rst_n = 1'b1;

    // R9: clock enable rising after reset, then steady
    drive(1, 1, 1, 1, 1, 13'h0, 2'd0, "R9 rise");
    drive(0, 1, 1, 1, 1, 13'h0, 2'd0, "R2 nop");
    // R4 activate, R3 deselected activate
    drive(0, 0, 1, 1, 1, 13'h1ABC, 2'd2, "R4 act");
    drive(1, 0, 1, 1, 1, 13'h0555, 2'd1, "R3 deselect");
    // R5 read / write with and without auto-precharge
    drive(0, 1, 0, 1, 1, 13'h02F3, 2'd1, "R5 read");
    drive(0, 1, 0, 0, 1, 13'h0555, 2'd3, "R5 write ap");
    drive(0, 1, 0, 1, 1, 13'h1400, 2'd0, "R7 read ap bank0");
    // R6 precharge single and all
    drive(0, 0, 1, 0, 1, 13'h0000, 2'd2, "R6 pre one");
    drive(0, 0, 1, 0, 1, 13'h0400, 2'd1, "R6 pre all");
    drive(0, 0, 0, 1, 1, 13'h1FFF, 2'd3, "R2 refresh");
    drive(0, 1, 1, 0, 1, 13'h1FFF, 2'd3, "R12 unused code");
    // R10 mode loads
    drive(0, 0, 0, 0, 1, 13'h006B, 2'd0, "R10 mode cl2.5 ilv bl8");
    drive(0, 0, 0, 0, 1, 13'h0021, 2'd0, "R10 mode cl2 seq bl2");
    drive(0, 0, 0, 0, 1, 13'h006A, 2'd1, "R10 mode bank1 ignored");
    drive(0, 0, 0, 0, 1, 13'h0077, 2'd0, "R10 mode illegal codes");
    // R8 power-down and self-refresh entries, R9 hold and exit
    drive(0, 0, 1, 1, 0, 13'h0F0F, 2'd3, "R8 act at fall -> pdn");
    drive(0, 1, 0, 1, 0, 13'h0111, 2'd1, "R9 held read");
    drive(1, 1, 1, 1, 0, 13'h0, 2'd0, "R9 held");
    drive(1, 1, 1, 1, 1, 13'h0, 2'd0, "R9 exit");
    drive(0, 0, 0, 1, 0, 13'h0, 2'd0, "R8 sref entry");
    drive(0, 0, 0, 1, 0, 13'h0, 2'd0, "R9 held sref");
    drive(0, 0, 0, 1, 1, 13'h0, 2'd0, "R9 exit sref");
    drive(1, 0, 0, 1, 1, 13'h0, 2'd0, "R3 deselect nop");
    drive(1, 0, 0, 1, 0, 13'h0, 2'd0, "R8 deselect fall -> pdn");
    drive(1, 1, 1, 1, 1, 13'h0, 2'd0, "R9 exit");
    drive(0, 1, 0, 1, 0, 13'h03FF, 2'd2, "R8 read at fall -> pdn");
    drive(0, 1, 1, 1, 1, 13'h0, 2'd0, "R9 exit");
    // random mix, R2 R11
    for (int i = 0; i < 400; i++) begin
      logic [3:0] p;
      p = 4'($urandom);
      drive(($urandom % 6) == 0, p[2], p[1], p[0], ($urandom % 8) != 0,
            13'($urandom), 2'($urandom), "R2 random");
    end
    repeat (3) @(posedge clk);
    #2;
    n_cmp++;
    if (q.size() != 0) begin
      n_bad++;
      $display("FAIL R2 drain: actual %0d left, expected 0", q.size());
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule